// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block recovers asynchronous serial characters from one receive line. A tick at sixteen times the bit rate, made elsewhere, paces a small state machine. Each bit is decided by a majority vote of three samples taken around the middle of its window. Characters carry 8 or 9 data bits, least significant bit first, and end with one stop bit. A low stop bit marks that character with a framing error.

Finished characters go into a two-entry FIFO. Each entry keeps the data byte, the ninth bit and the framing-error bit together. A read strobe pops the head entry. A level flag stays high while any entry is waiting. If a character finishes while the FIFO is full, the character is lost and a sticky overrun flag sets. From then on the receiver accepts nothing until its enable goes low and comes back high.

Two further controls exist. A polarity control inverts the line before any detection. In 9-bit mode an address filter keeps only characters whose ninth bit is one.

Top module: `uart_char_rx`

## Requirements
- R1: Reception starts on a falling edge of the polarity-corrected line. Each bit window is 16 ticks long. The bit value is the two-of-three majority of the samples on the 7th, 8th and 9th ticks of its window. Data arrives least significant bit first. In 8-bit mode `data_o` shows the byte and `bit9_o` reads 0.
- R2: With `nine_bit_i` high, a ninth data bit follows bit 7. It is presented on `bit9_o` with its character.
- R3: If the start bit does not vote to zero at mid-bit, the receiver returns to idle and stores no character.
- R4: The stop bit is voted one bit time after the last data bit. A zero gives `frame_err_o` = 1 for that character and a one gives 0. The character is stored in either case.
- R5: The FIFO holds two characters in arrival order. The data byte, the ninth bit and the framing flag of the oldest entry appear together on the outputs.
- R6: A pulse of `rd_i` pops one entry. `rx_irq_o` is high whenever at least one entry remains and goes low only once a pop empties the FIFO. `rd_i` has no effect on an empty FIFO.
- R7: A character that completes while both entries are full (and no pop happens in the same cycle) is discarded, and `overrun_o` sets.
- R8: While `overrun_o` is high, no new characters are received. Driving `rx_en_i` low clears the overrun flag, empties the FIFO and returns the receiver to idle.
- R9: With `invert_i` high, the line is inverted before start, data and stop detection. Inverted frames therefore give the same characters.
- R10: With `addr_det_i` and `nine_bit_i` both high, characters whose ninth bit is 0 are dropped. They set no flag. Characters whose ninth bit is 1 are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, asynchronous |
| tick16_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_en_i | input | 1 | Receive enable; low flushes the FIFO and clears overrun |
| nine_bit_i | input | 1 | Selects 9 data bits when high |
| addr_det_i | input | 1 | Keeps only characters with ninth bit 1 (9-bit mode) |
| invert_i | input | 1 | Inverts line polarity |
| rd_i | input | 1 | Pops the FIFO head |
| data_o | output | 8 | Head entry data byte |
| bit9_o | output | 1 | Head entry ninth bit |
| frame_err_o | output | 1 | Head entry framing error |
| rx_irq_o | output | 1 | FIFO not empty |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
A bit counter or vote window that slips would show up within a single character. The byte read at the head would come out shifted or would carry the wrong framing flag. A FIFO pointer or count fault shows on the first read after two characters are held: the order is wrong, or `rx_irq_o` drops early or stays high after the last pop. A broken stall or flush shows on the next character after an overrun or an enable toggle. That character either appears when it should not, or fails to appear when it should.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart_rx_line.sv
module uart_rx_line #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic invert_i,
  output logic line_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], rx_i};
  end

  // polarity applied after sync so idle always reads as 1
  assign line_o = sync_q[STAGES-1] ^ invert_i;
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              stall_i,
  input  logic              line_i,
  input  logic              tick_i,
  input  logic              nine_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              ferr_o
);
  localparam int CNT_W = $clog2(OS);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam int MID   = OS / 2;

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W:0]   sh_q;
  logic              v0_q, v1_q, line_prev_q, done_q, ferr_q;
  logic              at_mid, at_end, vote;
  logic [IDX_W-1:0]  last_idx;

  assign at_mid   = (cnt_q == CNT_W'(MID));
  assign at_end   = (cnt_q == CNT_W'(OS - 1));
  assign vote     = maj3(v0_q, v1_q, line_i);
  assign last_idx = nine_i ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      idx_q       <= '0;
      sh_q        <= '0;
      v0_q        <= 1'b1;
      v1_q        <= 1'b1;
      line_prev_q <= 1'b1;
      done_q      <= 1'b0;
      ferr_q      <= 1'b0;
    end else begin
      done_q      <= 1'b0;
      line_prev_q <= line_i;
      if (!en_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (!stall_i && line_prev_q && !line_i) begin
              state_q <= ST_START;
              cnt_q   <= '0;
              idx_q   <= '0;
              sh_q    <= '0;
            end
          end
          default: begin
            if (tick_i) begin
              cnt_q <= at_end ? '0 : cnt_q + 1'b1;
              if (cnt_q == CNT_W'(MID - 2)) v0_q <= line_i;
              if (cnt_q == CNT_W'(MID - 1)) v1_q <= line_i;
              case (state_q)
                ST_START: begin
                  if (at_mid && vote) state_q <= ST_IDLE;  // glitch
                  else if (at_end)    state_q <= ST_DATA;
                end
                ST_DATA: begin
                  if (at_mid) sh_q[idx_q] <= vote;
                  if (at_end) begin
                    if (idx_q == last_idx) state_q <= ST_STOP;
                    else                   idx_q   <= idx_q + 1'b1;
                  end
                end
                ST_STOP: begin
                  if (at_mid) begin
                    done_q  <= 1'b1;
                    ferr_q  <= !vote;
                    state_q <= ST_IDLE;
                  end
                end
                default: ;
              endcase
            end
          end
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign data_o = sh_q[DATA_W-1:0];
  assign bit9_o = nine_i & sh_q[DATA_W];
  assign ferr_o = ferr_q;

  AST_STALL_KEEPS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && state_q == ST_IDLE) |=> (state_q == ST_IDLE)); // R8
  AST_GLITCH_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START) |=> !done_o); // R3
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign pop_ok  = pop_i && !empty_o;
  assign push_ok = push_i && (!full_o || pop_ok);
  assign head_o  = mem_q[rd_q];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[g] <= '0;
      else if (push_ok && !flush_i && wr_q == PTR_W'(g)) mem_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i)); // R7
  AST_POP_EMPTY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> empty_o); // R6
endmodule

// File: rtl/uart_char_rx.sv
module uart_char_rx #(
  parameter int DATA_W      = 8,
  parameter int OS          = 16,
  parameter int FIFO_DEPTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick16_i,
  input  logic              rx_en_i,
  input  logic              nine_bit_i,
  input  logic              addr_det_i,
  input  logic              invert_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              frame_err_o,
  output logic              rx_irq_o,
  output logic              overrun_o
);
  localparam int ENT_W = DATA_W + 2;

  logic              line, done, c_bit9, c_ferr, keep, room, push, ovr_q;
  logic              empty, full;
  logic [DATA_W-1:0] c_data;
  logic [ENT_W-1:0]  head;

  uart_rx_line #(.STAGES(SYNC_STAGES)) u_line (
    .clk_i, .rst_ni, .rx_i, .invert_i, .line_o(line)
  );

  uart_rx_fsm #(.DATA_W(DATA_W), .OS(OS)) u_fsm (
    .clk_i, .rst_ni,
    .en_i   (rx_en_i),
    .stall_i(ovr_q),
    .line_i (line),
    .tick_i (tick16_i),
    .nine_i (nine_bit_i),
    .done_o (done),
    .data_o (c_data),
    .bit9_o (c_bit9),
    .ferr_o (c_ferr)
  );

  assign keep = !(addr_det_i && nine_bit_i && !c_bit9);
  assign room = !full || (rd_i && !empty);
  assign push = done && keep && room && !ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ovr_q <= 1'b0;
    else if (!rx_en_i)            ovr_q <= 1'b0;
    else if (done && keep && !room) ovr_q <= 1'b1;
  end

  uart_rx_fifo #(.WIDTH(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i(!rx_en_i),
    .push_i (push),
    .wdata_i({c_ferr, c_bit9, c_data}),
    .pop_i  (rd_i),
    .head_o (head),
    .empty_o(empty),
    .full_o (full)
  );

  assign data_o      = head[DATA_W-1:0];
  assign bit9_o      = head[DATA_W];
  assign frame_err_o = head[DATA_W+1];
  assign rx_irq_o    = !empty;
  assign overrun_o   = ovr_q;

  AST_EN_LOW_FLUSHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> (!rx_irq_o && !overrun_o)); // R8
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && rx_en_i) |=> overrun_o); // R8
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(rx_irq_o)); // R7
endmodule

// File: tb/uart_char_rx_bench.sv
module uart_char_rx_bench;
  localparam int TDIV = 4;
  localparam int BITC = 16 * TDIV;

  logic clk = 0, rst_n = 0;
  logic rx = 1, tick = 0, en = 0, nine = 0, adet = 0, inv = 0, rd = 0;
  logic [7:0] data;
  logic b9, fe, irq, ovr;
  int tests = 0, fails = 0;
  bit done = 0, auto_rd = 0;
  logic [9:0] exp_q[$];
  string tag_q[$];
  int div = 0;

  always #5 clk = ~clk;
  always @(posedge clk) begin
    div  <= (div == TDIV - 1) ? 0 : div + 1;
    tick <= (div == TDIV - 1);
  end

  uart_char_rx u_uart_char_rx (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tick16_i(tick), .rx_en_i(en),
    .nine_bit_i(nine), .addr_det_i(adet), .invert_i(inv), .rd_i(rd),
    .data_o(data), .bit9_o(b9), .frame_err_o(fe), .rx_irq_o(irq), .overrun_o(ovr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic put_bit(input logic b);
    rx = b ^ inv;
    repeat (BITC) @(negedge clk);
  endtask

  // driver: sends one frame and queues the expected entry
  task automatic send_frame(input logic [8:0] v, input bit stop, input bit expect_it, input string tag);
    if (expect_it) begin
      exp_q.push_back({~stop, nine ? v[8] : 1'b0, v[7:0]});
      tag_q.push_back(tag);
    end
    put_bit(1'b0);
    for (int i = 0; i < 8; i++) put_bit(v[i]);
    if (nine) put_bit(v[8]);
    put_bit(stop);
    put_bit(1'b1);
    if (!stop) put_bit(1'b1);
  endtask

  // monitor: pops and compares head against the queue
  initial begin
    forever begin
      @(negedge clk);
      if (rd) begin
        rd = 0;
        check("R6 irq after pop", {31'd0, irq}, {31'd0, exp_q.size() != 0});
      end else if (auto_rd && irq) begin
        if (exp_q.size() == 0) begin
          check("R3/R10 unexpected character", {22'd0, fe, b9, data}, 32'h0);
        end else begin
          automatic logic [9:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(t, {22'd0, fe, b9, data}, {22'd0, e});
        end
        rd = 1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset irq", {31'd0, irq}, 0);
    check("R7 reset overrun", {31'd0, ovr}, 0);
    rst_n = 1; en = 1; auto_rd = 1;
    repeat (BITC) @(negedge clk);

    // R1 8-bit patterns
    send_frame(9'h055, 1, 1, "R1 0x55");
    send_frame(9'h0A3, 1, 1, "R1 0xA3");
    send_frame(9'h000, 1, 1, "R1 0x00");
    send_frame(9'h0FF, 1, 1, "R1 0xFF");
    // R4 framing error then clean
    send_frame(9'h03C, 0, 1, "R4 stop low");
    send_frame(9'h03C, 1, 1, "R4 stop high");
    // R3 short start glitch
    rx = 0; repeat (2 * TDIV) @(negedge clk); rx = 1;
    repeat (3 * BITC) @(negedge clk);
    check("R3 glitch ignored", {31'd0, irq}, 0);
    // R2 nine-bit
    nine = 1;
    send_frame(9'h1C5, 1, 1, "R2 bit9 one");
    send_frame(9'h05A, 1, 1, "R2 bit9 zero");
    // R10 address filter
    adet = 1;
    send_frame(9'h012, 1, 0, "R10 dropped");
    send_frame(9'h134, 1, 1, "R10 kept");
    check("R10 no overrun from drop", {31'd0, ovr}, 0);
    adet = 0; nine = 0;
    // R9 inverted polarity
    @(negedge clk); inv = 1; rx = 0;
    repeat (3 * BITC) @(negedge clk);
    send_frame(9'h0B2, 1, 1, "R9 inverted 0xB2");
    send_frame(9'h04E, 0, 1, "R9 inverted stop low");
    @(negedge clk); inv = 0; rx = 1;
    repeat (3 * BITC) @(negedge clk);
    check("R9 queue drained", exp_q.size(), 0);

    // R5 R7 R8 overrun
    auto_rd = 0;
    send_frame(9'h011, 1, 1, "R5 first entry");
    send_frame(9'h022, 0, 1, "R5 second entry");
    send_frame(9'h033, 1, 0, "R7 lost");
    check("R7 overrun set", {31'd0, ovr}, 1);
    check("R5 irq held full", {31'd0, irq}, 1);
    send_frame(9'h044, 1, 0, "R8 stalled");
    check("R8 overrun sticky", {31'd0, ovr}, 1);
    auto_rd = 1;
    repeat (10) @(negedge clk);
    check("R8 stalled char not stored", {31'd0, irq}, 0);
    check("R5 drained", exp_q.size(), 0);
    en = 0; repeat (3) @(negedge clk);
    check("R8 overrun cleared", {31'd0, ovr}, 0);
    en = 1; repeat (BITC) @(negedge clk);
    send_frame(9'h066, 1, 1, "R8 after re-enable");
    repeat (10) @(negedge clk);

    // R8 flush on enable low
    auto_rd = 0;
    send_frame(9'h077, 1, 0, "R8 flushed");
    check("R8 pending before flush", {31'd0, irq}, 1);
    en = 0; repeat (3) @(negedge clk);
    check("R8 flush empties", {31'd0, irq}, 0);
    en = 1; auto_rd = 1;
    repeat (BITC) @(negedge clk);
    check("R1 all expected seen", exp_q.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule